// File: doc/BRIEF.md
# I2C register-access slave

This block sits between a two-wire (I2C) bus and a byte-wide register space of up to 256 locations. It works only as a slave. It filters and samples the SCL and SDA lines on a system clock and detects START, repeated START and STOP. It answers one 7-bit device address, which is set by a parameter. Each bus transaction becomes exactly one register access on a simple strobe/ready port.

A write sends the device address with the direction bit low, then a pointer byte, then one data byte. The data byte is committed to the register side before the slave acknowledges it. A read sends the pointer in the same way, then a repeated START, then the device address with the direction bit high. The slave fetches the register and sends that byte most significant bit first. While the register side is still working, the slave may hold SCL low, but only in the gap just before its own acknowledge bit. A general-call reset command drives a one-cycle reset pulse toward the register space.

Top module: `i2c_reg_slave`

## Requirements
- R1: During reset and straight after it, both open-drain enables (`scl_oe`, `sda_oe`) are low and `reg_we`, `reg_re` and `gc_reset` are low.
- R2: The slave acknowledges only the byte {DEV_ADDR, R/W}. DEV_ADDR defaults to 7'b1001000 and may be set to any value from 7'b1001000 to 7'b1001111. After any other non-general-call address it releases SDA (NACK) and ignores every bit until the next START or STOP.
- R3: A write of the form START, {addr,0}, pointer, data, STOP acknowledges all three bytes. It gives exactly one `reg_we` access with `reg_addr` equal to the pointer and `reg_wdata` equal to the data byte.
- R4: A read of the form START, {addr,0}, pointer, repeated START, {addr,1} gives exactly one `reg_re` access at the pointer. The returned `reg_rdata` byte is then driven on SDA, MSB first, in the next eight SCL periods.
- R5: A repeated START in the middle of a transaction is accepted without a STOP, and the pointer written before it is kept for the read that follows.
- R6: SCL is held low only in the gap between the end of a received byte and the slave's ACK bit, and only while a register strobe is pending. It is released once `reg_ready` has been seen.
- R7: General call {7'b0000000,0} is acknowledged. A following byte 8'h06 is acknowledged and produces a one-cycle `gc_reset` pulse. Any other byte there is NACKed and produces no pulse.
- R8: A START or STOP at any bit position abandons the current byte and restarts address reception. A partly received data byte is never written.
- R9: After the single data byte of a write, further bytes are NACKed and not written.
- R10: `reg_we` and `reg_re` are never high together. Each stays high, with a stable address and write data, until `reg_ready` is seen, and each makes a single access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low (ACK or data 0) |
| reg_addr | output | AW | Register pointer |
| reg_wdata | output | 8 | Data for a register write |
| reg_we | output | 1 | Write request, held until ready |
| reg_re | output | 1 | Read request, held until ready |
| reg_rdata | input | 8 | Register read data, valid with ready |
| reg_ready | input | 1 | Register side completes the pending request |
| gc_reset | output | 1 | One-cycle reset pulse from a general call |

## Verification
The write/read pairs use pointers at both ends of the space (00, FF) and in between, and data bytes of all zeros, all ones and alternating bits. A reversed or shifted bit order therefore shows up as a wrong readback. Register-side delays range from none to sixteen cycles. This shows that SCL is held for at least the wait time while the data bits never see a stretch. The remaining patterns cover a foreign address, a general call with the right and the wrong command, aborts by STOP and by START in mid-byte, and a surplus data byte. Each of these separates correct ignoring from a spurious write, read or reset pulse.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] GC_CMD_RESET = 8'h06;

  typedef enum logic [2:0] {
    ST_IDLE,     // ignore the bus until START
    ST_RX,       // shifting in a byte
    ST_DECIDE,   // 8 bits in, waiting for SCL fall to act
    ST_STRETCH,  // SCL held low, strobe pending
    ST_ACK,      // ACK driven, waiting for SCL rise
    ST_ACK_END,  // ACK driven, waiting for SCL fall
    ST_TX        // shifting out a read byte
  } slv_state_t;

  typedef enum logic [2:0] {
    K_DEV,    // device address byte
    K_PTR,    // register pointer byte
    K_WDATA,  // write data byte
    K_GC,     // general-call command byte
    K_DONE    // transaction complete, no more bytes accepted
  } byte_kind_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // SDA edges while SCL stays high frame a transaction
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_slv_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1001000,
  parameter int         AW       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_oe,
  output logic              scl_oe,
  output logic [AW-1:0]     reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [BYTE_W-1:0] reg_rdata,
  input  logic              reg_ready,
  output logic              gc_reset
);
  slv_state_t        state;
  byte_kind_t        kind;
  logic [BYTE_W-1:0] shreg;
  logic [2:0]        bitcnt;
  logic              tx_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      kind      <= K_DEV;
      shreg     <= '0;
      bitcnt    <= '0;
      tx_next   <= 1'b0;
      sda_oe    <= 1'b0;
      scl_oe    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
      gc_reset  <= 1'b0;
    end else begin
      gc_reset <= 1'b0;
      if (start_det) begin
        state   <= ST_RX;
        kind    <= K_DEV;
        bitcnt  <= '0;
        tx_next <= 1'b0;
        sda_oe  <= 1'b0;
        scl_oe  <= 1'b0;
        reg_we  <= 1'b0;
        reg_re  <= 1'b0;
      end else if (stop_det) begin
        state   <= ST_IDLE;
        tx_next <= 1'b0;
        sda_oe  <= 1'b0;
        scl_oe  <= 1'b0;
        reg_we  <= 1'b0;
        reg_re  <= 1'b0;
      end else begin
        case (state)
          ST_RX: if (scl_rise) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) state <= ST_DECIDE;
          end
          ST_DECIDE: if (scl_fall) begin
            case (kind)
              K_DEV: begin
                if (shreg[7:1] == DEV_ADDR) begin
                  if (shreg[0]) begin
                    reg_re  <= 1'b1;
                    scl_oe  <= 1'b1;
                    tx_next <= 1'b1;
                    state   <= ST_STRETCH;
                  end else begin
                    sda_oe <= 1'b1;
                    kind   <= K_PTR;
                    state  <= ST_ACK;
                  end
                end else if (shreg == 8'h00) begin
                  sda_oe <= 1'b1;
                  kind   <= K_GC;
                  state  <= ST_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end
              K_PTR: begin
                reg_addr <= shreg[AW-1:0];
                sda_oe   <= 1'b1;
                kind     <= K_WDATA;
                state    <= ST_ACK;
              end
              K_WDATA: begin
                reg_wdata <= shreg;
                reg_we    <= 1'b1;
                scl_oe    <= 1'b1;
                state     <= ST_STRETCH;
              end
              K_GC: begin
                if (shreg == GC_CMD_RESET) begin
                  sda_oe   <= 1'b1;
                  gc_reset <= 1'b1;
                  kind     <= K_DONE;
                  state    <= ST_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end
              default: state <= ST_IDLE;
            endcase
          end
          ST_STRETCH: if (reg_ready) begin
            if (reg_re) shreg <= reg_rdata;
            reg_we <= 1'b0;
            reg_re <= 1'b0;
            scl_oe <= 1'b0;
            sda_oe <= 1'b1;
            kind   <= K_DONE;
            state  <= ST_ACK;
          end
          ST_ACK: if (scl_rise) state <= ST_ACK_END;
          ST_ACK_END: if (scl_fall) begin
            bitcnt <= '0;
            if (tx_next) begin
              sda_oe <= ~shreg[7];
              state  <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= (kind == K_DONE) ? ST_IDLE : ST_RX;
            end
          end
          ST_TX: if (scl_fall) begin
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              sda_oe  <= 1'b0;
              tx_next <= 1'b0;
              state   <= ST_IDLE;
            end else begin
              sda_oe <= ~shreg[6];
              shreg  <= {shreg[BYTE_W-2:0], 1'b0};
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_re));
  // R10
  strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((reg_we || reg_re) && !reg_ready) |=>
      ((reg_we || reg_re) && $stable(reg_addr) && $stable(reg_wdata)));
  // R6
  stretch_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_oe) |-> $past(reg_ready));
  // R6
  stretch_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    scl_oe |-> (reg_we || reg_re));
  // R7
  gc_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    gc_reset |=> !gc_reset);
  // R3
  sda_pull_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'b1001000,
  parameter int         AW          = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic [AW-1:0] reg_addr,
  output logic [7:0]    reg_wdata,
  output logic          reg_we,
  output logic          reg_re,
  input  logic [7:0]    reg_rdata,
  input  logic          reg_ready,
  output logic          gc_reset
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  // R2: selectable device addresses share the upper four bits
  initial begin
    dev_addr_range_chk: assert (DEV_ADDR[6:3] == 4'b1001)
      else $error("DEV_ADDR outside 1001000..1001111");
  end

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_slave_fsm #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .scl_oe    (scl_oe),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .reg_rdata (reg_rdata),
    .reg_ready (reg_ready),
    .gc_reset  (gc_reset)
  );
endmodule

// File: tb/tb_i2c_reg_slave.sv
module tb_i2c_reg_slave;
  localparam int Q = 44;
  localparam logic [6:0] ADDR = 7'b1001000;
  // {pointer, data, ready wait}
  localparam logic [23:0] VEC [0:5] = '{
    24'h10_3C_00, 24'hFF_00_01, 24'h00_FF_04,
    24'h7E_81_10, 24'h55_AA_00, 24'hA0_5A_02
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe, reg_we, reg_re, reg_ready, gc_reset;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic scl_line, sda_line;
  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;

  i2c_reg_slave dut (
    .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
    .reg_rdata(reg_rdata), .reg_ready(reg_ready), .gc_reset(gc_reset)
  );

  // register-side model
  logic [7:0] mem [0:255];
  int wait_cfg = 0;
  int wcnt = 0;
  int wr_cnt = 0, rd_cnt = 0, gc_cnt = 0, str_cnt = 0, bad_str = 0;
  assign reg_ready = (reg_we | reg_re) && (wcnt >= wait_cfg);
  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) begin
    if (reg_we | reg_re) wcnt <= wcnt + 1; else wcnt <= 0;
    if (reg_we && reg_ready) begin
      mem[reg_addr] <= reg_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (reg_re && reg_ready) rd_cnt <= rd_cnt + 1;
    if (gc_reset) gc_cnt <= gc_cnt + 1;
    if (scl_oe) str_cnt <= str_cnt + 1;
    if (scl_oe && !(reg_we || reg_re)) bad_str <= bad_str + 1;
  end

  int n_chk = 0, n_err = 0;
  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic quarter(); repeat (Q) @(negedge clk); endtask
  task automatic scl_up();
    scl_m = 1'b1;
    @(negedge clk);
    while (!scl_line) @(negedge clk);
    quarter();
  endtask
  task automatic scl_down(); scl_m = 1'b0; quarter(); endtask
  task automatic i2c_start();
    sda_m = 1'b1; quarter(); scl_up(); sda_m = 1'b0; quarter(); scl_down();
  endtask
  task automatic i2c_stop();
    sda_m = 1'b0; quarter(); scl_up(); sda_m = 1'b1; quarter();
  endtask
  task automatic put_bit(input logic b);
    sda_m = b; quarter(); scl_up(); scl_down();
  endtask
  task automatic get_bit(output logic b);
    sda_m = 1'b1; quarter(); scl_up(); b = sda_line; scl_down();
  endtask
  task automatic put_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = !b;
  endtask
  task automatic get_byte(output logic [7:0] v, input logic nack);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(nack);
  endtask
  task automatic wr_txn(input logic [7:0] ptr, input logic [7:0] data,
                        output logic a0, output logic a1, output logic a2);
    i2c_start(); put_byte({ADDR, 1'b0}, a0); put_byte(ptr, a1);
    put_byte(data, a2); i2c_stop();
  endtask
  task automatic rd_txn(input logic [7:0] ptr, output logic [7:0] d,
                        output logic a0, output logic a1, output logic a2);
    i2c_start(); put_byte({ADDR, 1'b0}, a0); put_byte(ptr, a1);
    i2c_start(); put_byte({ADDR, 1'b1}, a2); get_byte(d, 1'b1); i2c_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk + 1, n_err + 1);
    $finish;
  end

  initial begin
    logic a0, a1, a2, a3;
    logic [7:0] d;
    int w0, r0, s0, g0;
    // R1 reset state
    repeat (5) @(negedge clk);
    chk(!scl_oe && !sda_oe, "R1", "oe during reset", {scl_oe, sda_oe}, 0);
    chk(!reg_we && !reg_re && !gc_reset, "R1", "strobes during reset",
        {reg_we, reg_re, gc_reset}, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(!scl_oe && !sda_oe && !reg_we && !reg_re, "R1", "after reset",
        {scl_oe, sda_oe, reg_we, reg_re}, 0);

    // table walk: write then read back
    for (int k = 0; k < 6; k++) begin
      wait_cfg = int'(VEC[k][7:0]);
      w0 = wr_cnt; s0 = str_cnt; r0 = rd_cnt;
      wr_txn(VEC[k][23:16], VEC[k][15:8], a0, a1, a2);
      chk(a0 && a1 && a2, "R3", "write acks", {a0, a1, a2}, 7);
      chk(wr_cnt == w0 + 1, "R10", "one write", wr_cnt - w0, 1);
      chk(mem[VEC[k][23:16]] == VEC[k][15:8], "R3", "written value",
          mem[VEC[k][23:16]], VEC[k][15:8]);
      chk(str_cnt - s0 >= wait_cfg + 1, "R6", "stretch covers wait",
          str_cnt - s0, wait_cfg + 1);
      rd_txn(VEC[k][23:16], d, a0, a1, a2);
      chk(a0 && a1 && a2, "R5", "read acks with repeated START", {a0, a1, a2}, 7);
      chk(d == VEC[k][15:8], "R4", "read data", d, VEC[k][15:8]);
      chk(rd_cnt == r0 + 1, "R10", "one read", rd_cnt - r0, 1);
    end
    wait_cfg = 0;

    // R2 foreign address ignored
    w0 = wr_cnt; r0 = rd_cnt;
    i2c_start(); put_byte({7'b1001001, 1'b0}, a0); put_byte(8'h10, a1);
    put_byte(8'h99, a2); i2c_stop();
    chk(!a0 && !a1 && !a2, "R2", "foreign address NACKed", {a0, a1, a2}, 0);
    chk(wr_cnt == w0 && mem[8'h10] == 8'h3C, "R2", "no write on foreign address",
        mem[8'h10], 8'h3C);

    // R7 general call
    g0 = gc_cnt;
    i2c_start(); put_byte(8'h00, a0); put_byte(8'h06, a1); i2c_stop();
    chk(a0 && a1, "R7", "general call acks", {a0, a1}, 3);
    chk(gc_cnt == g0 + 1, "R7", "reset pulse", gc_cnt - g0, 1);
    g0 = gc_cnt;
    i2c_start(); put_byte(8'h00, a0); put_byte(8'h04, a1); i2c_stop();
    chk(a0 && !a1, "R7", "bad command NACK", {a0, a1}, 2);
    chk(gc_cnt == g0, "R7", "no pulse on bad command", gc_cnt - g0, 0);

    // R8 STOP in mid data byte: nothing written
    w0 = wr_cnt;
    i2c_start(); put_byte({ADDR, 1'b0}, a0); put_byte(8'h10, a1);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); i2c_stop();
    chk(wr_cnt == w0, "R8", "partial byte not written", wr_cnt - w0, 0);
    rd_txn(8'h10, d, a0, a1, a2);
    chk(d == 8'h3C, "R8", "register kept after abort", d, 8'h3C);

    // R8 START in mid address byte restarts reception
    i2c_start(); put_bit(1'b1); put_bit(1'b0); put_bit(1'b0);
    rd_txn(8'hFF, d, a0, a1, a2);
    chk(a0 && a1 && a2, "R8", "acks after START abort", {a0, a1, a2}, 7);
    chk(d == 8'h00, "R8", "read after START abort", d, 8'h00);

    // R9 surplus data byte
    w0 = wr_cnt;
    i2c_start(); put_byte({ADDR, 1'b0}, a0); put_byte(8'h55, a1);
    put_byte(8'h11, a2); put_byte(8'h22, a3); i2c_stop();
    chk(a0 && a1 && a2 && !a3, "R9", "surplus byte NACK", {a0, a1, a2, a3}, 14);
    chk(wr_cnt == w0 + 1 && mem[8'h55] == 8'h11, "R9", "only first byte written",
        mem[8'h55], 8'h11);

    // R6 no stretch outside a pending request
    chk(bad_str == 0, "R6", "stretch without request", bad_str, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule